// File: doc/BRIEF.md
# Emulation Select and ROM Wait Acknowledge

This block sits beside the internal bus of a microcontroller and serves an external emulator. While the chip runs in emulation mode, it watches each bus cycle that the address strobe opens. When the cycle addresses one of a fixed set of port registers, it drives an active-low emulator select pin. It also raises an inhibit so that the internal register file stays silent, and an external port replacement device answers instead. When the cycle falls inside the on-chip ROM array and the ROM is enabled, it drives an active-low module select pin. It then waits a programmed number of clocks and returns a 16-bit data-size acknowledge.

A small state machine tracks each strobe. `ST_IDLE` decodes the first sampled strobe-low cycle and moves to `ST_EMU` (port register hit in emulation mode), `ST_ROM_WAIT` (enabled ROM hit in emulation mode) or `ST_PASS` (anything else). `ST_ROM_WAIT` loads a down-counter with the wait field on entry. It steps to `ST_ROM_ACK` in the edge where the counter reads zero. Every state returns to `ST_IDLE` on the first edge that samples the strobe high. A two-bit pin configuration decides whether each pin carries its select. No other configuration affects the pins.

Top module: `emu_select_unit`

## Requirements
- R1: With `emu_mode`=1 and `pin_cfg[0]`=1, a bus cycle to a port register drives `emu_sel_n` low from the first clock edge that samples `as_n` low. The pin stays low until `as_n` rises.
- R2: The port registers are the addresses 0xFFFA00 + offset, where the offset is one of 0x10, 0x11, 0x12, 0x13, 0x14, 0x18, 0x19, 0x1A, 0x1B, 0x1C or 0x1F. Any other address, including 0xFFFA15, 0xFFFA1D and 0xFFFB10, never asserts `emu_sel_n`.
- R3: `reg_inhibit` is high in every cycle where `as_n`=0, `emu_mode`=1 and the address is a port register. This holds regardless of `pin_cfg`, and `size_ack` stays 2'b00 throughout.
- R4: With `emu_mode`=1, `rom_en`=1 and `pin_cfg[1]`=1, a ROM hit drives `mod_sel_n` low from the first edge that samples `as_n` low. The pin stays low until `as_n` rises.
- R5: An address is a ROM hit when `addr[23:16]` equals `rom_tag` and `addr[15:0]` < 0xC000. The last hit is 0x..BFFF, and 0x..C000 is a miss.
- R6: On a ROM hit, `size_ack` becomes 2'b01 (16-bit code; 2'b00 means none) exactly `wait_sel`+1 clocks after `mod_sel_n` falls. It holds until `as_n` rises.
- R7: `emu_sel_n`, `mod_sel_n` and `size_ack` return to their idle values in the same cycle that `as_n` goes high. A new cycle after one idle clock decodes afresh.
- R8: With `emu_mode`=0, both selects stay high, `size_ack` stays 2'b00 and `reg_inhibit` stays low for every address.
- R9: `pin_cfg[0]`=0 keeps `emu_sel_n` high and `pin_cfg[1]`=0 keeps `mod_sel_n` high. The inhibit and the ROM acknowledge timing are unchanged.
- R10: With `rom_en`=0, a ROM-range address produces no module select and no acknowledge.
- R11: While `rst_n` is low, both selects are high, `size_ack` is 2'b00 and `reg_inhibit` is low (with `as_n` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode | input | 1 | Emulation mode enable |
| rom_en | input | 1 | On-chip ROM enabled |
| pin_cfg | input | 2 | Bit 0: pin carries emulator select; bit 1: pin carries module select |
| rom_tag | input | 8 | Upper address bits of the ROM base |
| wait_sel | input | 2 | ROM wait-state count, 0 to 3 |
| as_n | input | 1 | Active-low address strobe |
| addr | input | 24 | Bus address |
| emu_sel_n | output | 1 | Active-low emulator select |
| mod_sel_n | output | 1 | Active-low ROM module select |
| size_ack | output | 2 | Data-size acknowledge code to the bus |
| reg_inhibit | output | 1 | Tells the internal register file not to respond |

## Verification
The assertions assume that `addr`, `emu_mode`, `rom_en`, `pin_cfg`, `rom_tag` and `wait_sel` stay stable while `as_n` is low. Under that assumption, the state captured at the first strobe edge agrees with the live decode. The bench changes these inputs only on falling clock edges while the strobe is high. It always leaves at least one idle clock between bus cycles, so every cycle starts from `ST_IDLE`.

// File: rtl/emu_sel_pkg.sv
package emu_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EMU,
        ST_ROM_WAIT,
        ST_ROM_ACK,
        ST_PASS
    } emu_st_e;

    localparam logic [1:0] ACK_NONE = 2'b00;
    localparam logic [1:0] ACK_16   = 2'b01;

    // Offsets inside the register page that the emulator maps externally.
    function automatic logic is_port_offset(input logic [7:0] off);
        case (off)
            8'h10, 8'h11, 8'h12, 8'h13, 8'h14,
            8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C,
            8'h1F:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/emu_addr_decode.sv
module emu_addr_decode #(
    parameter int ADDR_W    = 24,
    parameter int ALIGN_W   = 16,
    parameter int ROM_BYTES = 49152,
    parameter logic [ADDR_W-9:0] REG_PAGE = 16'hFFFA
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-ALIGN_W-1:0] rom_tag,
    output logic                      port_hit,
    output logic                      rom_hit
);
    import emu_sel_pkg::*;

    localparam logic [ALIGN_W:0] ROM_LIMIT = (ALIGN_W+1)'(ROM_BYTES);

    always_comb begin
        port_hit = (addr[ADDR_W-1:8] == REG_PAGE) && is_port_offset(addr[7:0]);
        rom_hit  = (addr[ADDR_W-1:ALIGN_W] == rom_tag) &&
                   ({1'b0, addr[ALIGN_W-1:0]} < ROM_LIMIT);
    end

endmodule

// File: rtl/rom_wait_count.sv
module rom_wait_count #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              is_zero
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);

    // R6: each counted clock removes exactly one wait state
    p_wait_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/emu_select_unit.sv
module emu_select_unit #(
    parameter int ADDR_W    = 24,
    parameter int ALIGN_W   = 16,
    parameter int ROM_BYTES = 49152,
    parameter int WAIT_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      emu_mode,
    input  logic                      rom_en,
    input  logic [1:0]                pin_cfg,
    input  logic [ADDR_W-ALIGN_W-1:0] rom_tag,
    input  logic [WAIT_W-1:0]         wait_sel,
    input  logic                      as_n,
    input  logic [ADDR_W-1:0]         addr,
    output logic                      emu_sel_n,
    output logic                      mod_sel_n,
    output logic [1:0]                size_ack,
    output logic                      reg_inhibit
);
    import emu_sel_pkg::*;

    emu_st_e state_q, state_d;
    logic    port_hit, rom_hit, wait_zero, wait_load, wait_dec;

    emu_addr_decode #(
        .ADDR_W   (ADDR_W),
        .ALIGN_W  (ALIGN_W),
        .ROM_BYTES(ROM_BYTES)
    ) u_decode (
        .addr    (addr),
        .rom_tag (rom_tag),
        .port_hit(port_hit),
        .rom_hit (rom_hit)
    );

    rom_wait_count #(.WAIT_W(WAIT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wait_load),
        .load_val(wait_sel),
        .dec     (wait_dec),
        .is_zero (wait_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!as_n) begin
                    if (emu_mode && port_hit)
                        state_d = ST_EMU;
                    else if (emu_mode && rom_en && rom_hit)
                        state_d = ST_ROM_WAIT;
                    else
                        state_d = ST_PASS;
                end
            end
            ST_EMU, ST_PASS, ST_ROM_ACK: begin
                if (as_n) state_d = ST_IDLE;
            end
            ST_ROM_WAIT: begin
                if (as_n)           state_d = ST_IDLE;
                else if (wait_zero) state_d = ST_ROM_ACK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wait_load = (state_q == ST_IDLE) && (state_d == ST_ROM_WAIT);
    assign wait_dec  = (state_q == ST_ROM_WAIT);

    // Outputs: gated by the live strobe so they drop as soon as it negates
    always_comb begin
        emu_sel_n   = !((state_q == ST_EMU) && !as_n && pin_cfg[0]);
        mod_sel_n   = !(((state_q == ST_ROM_WAIT) || (state_q == ST_ROM_ACK))
                        && !as_n && pin_cfg[1]);
        size_ack    = ((state_q == ST_ROM_ACK) && !as_n) ? ACK_16 : ACK_NONE;
        reg_inhibit = !as_n && emu_mode && port_hit;
    end

    // R8: nothing external happens outside emulation mode
    p_quiet_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_mode |-> (emu_sel_n && mod_sel_n && !reg_inhibit && size_ack == ACK_NONE));

    // R7: strobe negation releases every output
    p_release_on_as_r7: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (emu_sel_n && mod_sel_n && size_ack == ACK_NONE));

    // R10: disabled ROM never selects or acknowledges
    p_rom_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_en |-> (mod_sel_n && size_ack == ACK_NONE));

    // R6: acknowledge only starts after the wait state
    p_ack_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(size_ack == ACK_16) |-> $past(state_q == ST_ROM_WAIT));

    // R3: an inhibited port cycle never gets the ROM acknowledge
    p_inhibit_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_inhibit |-> (size_ack == ACK_NONE));

    // R1: emulator select only follows a sampled strobe
    p_emu_after_as_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_sel_n |-> $past(!as_n));

    // R4: the two selects are never active together
    p_sel_mutex_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!emu_sel_n && !mod_sel_n));

endmodule

// File: tb/emu_select_unit_tb.sv
module emu_select_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        emu_mode = 1'b0;
    logic        rom_en = 1'b0;
    logic [1:0]  pin_cfg = 2'b00;
    logic [7:0]  rom_tag = 8'h00;
    logic [1:0]  wait_sel = 2'b00;
    logic        as_n = 1'b1;
    logic [23:0] addr = 24'h0;
    logic        emu_sel_n, mod_sel_n, reg_inhibit;
    logic [1:0]  size_ack;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R11";
    bit    done     = 1'b0;

    // Model state
    int m_phase = 0;   // 0 idle, 1 emulator, 2 rom, 3 other
    int m_cnt   = 0;

    always #4 clk = ~clk;   // 125 MHz

    emu_select_unit dut_i (
        .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .rom_en(rom_en),
        .pin_cfg(pin_cfg), .rom_tag(rom_tag), .wait_sel(wait_sel),
        .as_n(as_n), .addr(addr), .emu_sel_n(emu_sel_n), .mod_sel_n(mod_sel_n),
        .size_ack(size_ack), .reg_inhibit(reg_inhibit)
    );

    function automatic bit m_port(input logic [23:0] a);
        int offs[11] = '{'h10, 'h11, 'h12, 'h13, 'h14, 'h18, 'h19, 'h1A, 'h1B, 'h1C, 'h1F};
        if (a[23:8] != 16'hFFFA) return 1'b0;
        foreach (offs[i]) if (int'(a[7:0]) == offs[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_rom(input logic [23:0] a, input logic [7:0] tag);
        return (a[23:16] == tag) && (int'(a[15:0]) < 49152);
    endfunction

    always @(posedge clk) begin
        if (!rst_n || as_n) begin
            m_phase <= 0;
            m_cnt   <= 0;
        end else if (m_phase == 0) begin
            if (emu_mode && m_port(addr))                        m_phase <= 1;
            else if (emu_mode && rom_en && m_rom(addr, rom_tag)) m_phase <= 2;
            else                                                 m_phase <= 3;
            m_cnt <= 0;
        end else if (m_phase == 2) begin
            m_cnt <= m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, cur_req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!done) begin
            chk("emu_sel_n R1 R2 R9", int'(emu_sel_n),
                int'(!(m_phase == 1 && !as_n && pin_cfg[0])));
            chk("mod_sel_n R4 R5 R9 R10", int'(mod_sel_n),
                int'(!(m_phase == 2 && !as_n && pin_cfg[1])));
            chk("size_ack R6 R10", int'(size_ack),
                (m_phase == 2 && m_cnt > int'(wait_sel) && !as_n) ? 1 : 0);
            chk("reg_inhibit R3", int'(reg_inhibit),
                int'(!as_n && emu_mode && m_port(addr)));
        end
    end

    task automatic bus_cycle(input logic [23:0] a, input int hold, input string tag);
        @(negedge clk);
        cur_req = tag;
        addr = a;
        as_n = 1'b0;
        repeat (hold) @(negedge clk);
        as_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        cur_req = "R11";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        emu_mode = 1'b1; rom_en = 1'b1; pin_cfg = 2'b11; rom_tag = 8'h04; wait_sel = 2'd0;

        bus_cycle(24'hFFFA10, 4, "R1 R2");
        bus_cycle(24'hFFFA1C, 3, "R2");
        bus_cycle(24'hFFFA1F, 3, "R2");
        bus_cycle(24'hFFFA14, 2, "R2");
        bus_cycle(24'hFFFA15, 3, "R2 miss");
        bus_cycle(24'hFFFA1D, 3, "R2 miss");
        bus_cycle(24'hFFFB10, 3, "R2 miss");

        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            wait_sel = 2'(w);
            bus_cycle(24'h040000, 7, "R4 R6");
        end
        wait_sel = 2'd2;
        bus_cycle(24'h04BFFF, 6, "R5 last");
        bus_cycle(24'h04C000, 6, "R5 above");
        bus_cycle(24'h03FFFF, 6, "R5 below");
        bus_cycle(24'h040000, 2, "R6 R7 early");

        @(negedge clk); pin_cfg = 2'b00;
        bus_cycle(24'hFFFA11, 3, "R9 R3");
        bus_cycle(24'h041234, 6, "R9 rom");
        @(negedge clk); pin_cfg = 2'b10;
        bus_cycle(24'hFFFA12, 3, "R9");
        @(negedge clk); pin_cfg = 2'b11;

        @(negedge clk); rom_en = 1'b0;
        bus_cycle(24'h040010, 6, "R10");
        bus_cycle(24'hFFFA18, 3, "R10 port");
        @(negedge clk); rom_en = 1'b1;

        @(negedge clk); emu_mode = 1'b0;
        bus_cycle(24'hFFFA10, 4, "R8");
        bus_cycle(24'h040000, 6, "R8");
        @(negedge clk); emu_mode = 1'b1; wait_sel = 2'd1;

        bus_cycle(24'hFFFA13, 1, "R7");
        bus_cycle(24'h040100, 5, "R7");
        bus_cycle(24'hFFFA1B, 2, "R7");

        @(negedge clk); rst_n = 1'b0; cur_req = "R11";
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule